// File: doc/BRIEF.md
# Composite Clock Violation Decoder

This block decodes a 64 kbit/s composite timing signal whose ternary return-to-zero symbols arrive as two already-sampled rail indications, one for positive marks and one for negative marks, qualified by a one-cycle bit tick per bit period. It follows alternate-mark-inversion polarity and flags any mark that repeats the polarity of the mark before it. Those deliberate violations, one every eight bits, are used as the frame marker from which an 8 kHz frame sync and a frame lock flag are derived.

In the extended variant every twentieth frame carries no violation. The decoder treats that gap as a second, slower marker instead of an error: it yields a 400 Hz superframe sync and a superframe lock flag, and does not let the scheduled gap count against frame lock. A loss-of-signal alarm covers long runs without marks. A three-bit mode input enables the block for one of the two variants. Every other mode code holds the block idle.

Top module: `cc_violation_decoder`

## Requirements
- R1: Only mode codes 3'b000 (basic, violation every 8 bits) and 3'b001 (extended, a violation gap every 20 frames) enable the block. For any other code, every output is low in the cycle after that code is present and all tracking state is cleared.
- R2: With a valid mode, bit_stb_o is high for exactly the one cycle after each cycle in which bit_tick_i is high.
- R3: data_pos_o and data_neg_o are return-to-zero copies of the rails, high only together with bit_stb_o: data_pos_o = 1 for a tick with only the positive rail high, data_neg_o = 1 for a tick with only the negative rail high. A tick with both rails high is not a mark and drives neither.
- R4: A mark is a violation when its polarity equals the polarity of the previous mark. The polarity memory is updated on every mark, violations included.
- R5: While unlocked, the first violation anchors the frame. frame_lock_o rises in the cycle after the tick of the fourth following violation, when each of the four is exactly 8 bits after the one before it. That cycle also carries a frame_sync_o pulse.
- R6: While locked, frame_sync_o pulses together with bit_stb_o on every eighth bit, at the position where the violation is due, whether or not the violation is present.
- R7: Three consecutive due positions without a violation drop frame_lock_o after the third such tick, and frame_sync_o is not pulsed on that tick.
- R8: In extended mode, a gap that falls exactly 20 frames after the previous gap does not count toward loss of frame lock.
- R9: In extended mode, sframe_lock_o rises on the second of two gaps spaced exactly 20 frames apart. From then on, sframe_sync_o pulses for one bit strobe on every gap frame, together with frame_sync_o.
- R10: los_o rises in the cycle after the 32nd consecutive tick without a mark, stays high through further markless ticks, and falls in the cycle after the first tick with a mark.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Mode code: 000 basic, 001 extended, others idle |
| bit_tick_i | input | 1 | One-cycle qualifier for each 64 kHz bit period |
| rail_pos_i | input | 1 | Sampled positive-rail mark indication |
| rail_neg_i | input | 1 | Sampled negative-rail mark indication |
| bit_stb_o | output | 1 | Recovered bit strobe |
| data_pos_o | output | 1 | Return-to-zero positive mark output |
| data_neg_o | output | 1 | Return-to-zero negative mark output |
| frame_sync_o | output | 1 | 8 kHz frame sync pulse |
| sframe_sync_o | output | 1 | 400 Hz superframe sync pulse |
| frame_lock_o | output | 1 | Frame alignment locked |
| sframe_lock_o | output | 1 | Superframe alignment locked |
| los_o | output | 1 | Loss-of-signal alarm |

## Verification
Every output comes from a register that loads at the clock edge on which bit_tick_i is sampled, so each result is due exactly one cycle after the tick that causes it: strobe, rail data, sync pulses, lock changes and the alarm. The bench drives each tick on a falling edge, drops it on the next falling edge and samples all outputs at that same falling edge, midway through the cycle after the capturing edge. It then leaves two idle cycles before the next bit. Lock, gap and alarm instants are predicted as bit indices from the encoded pattern: lock on bit 39, superframe lock on bit 319, loss of lock on the third missing position, the alarm on the 32nd empty bit. They are compared bit by bit at that sampling point.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  localparam logic [2:0] MODE_BASIC = 3'b000;
  localparam logic [2:0] MODE_SUPER = 3'b001;

  typedef struct packed {
    logic tick;
    logic mark;
    logic pol;
    logic viol;
  } sym_t;

  function automatic logic mode_valid(input logic [2:0] m);
    return (m == MODE_BASIC) || (m == MODE_SUPER);
  endfunction

endpackage

// File: rtl/ccd_rst_sync.sv
module ccd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ccd_ami_tracker.sv
module ccd_ami_tracker
  import ccd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic pos,
  input  logic neg,
  output sym_t sym
);
  logic last_pol_q, last_pol_d;
  logic seen_q, seen_d;
  logic mark;

  assign mark = en && tick && (pos ^ neg);

  always_comb begin
    sym.tick = en && tick;
    sym.mark = mark;
    sym.pol  = pos;
    sym.viol = mark && seen_q && (pos == last_pol_q);
  end

  always_comb begin
    last_pol_d = last_pol_q;
    seen_d     = seen_q;
    if (!en) begin
      last_pol_d = 1'b0;
      seen_d     = 1'b0;
    end else if (mark) begin
      last_pol_d = pos;
      seen_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pol_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      last_pol_q <= last_pol_d;
      seen_q     <= seen_d;
    end
  end
endmodule

// File: rtl/ccd_los_monitor.sv
module ccd_los_monitor
  import ccd_pkg::*;
#(
  parameter int LOS_N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  sym_t sym,
  output logic los
);
  localparam int CW = $clog2(LOS_N + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          los_q, los_d;

  always_comb begin
    cnt_d = cnt_q;
    los_d = los_q;
    if (!en) begin
      cnt_d = '0;
      los_d = 1'b0;
    end else if (sym.tick) begin
      if (sym.mark) begin
        cnt_d = '0;
        los_d = 1'b0;
      end else begin
        if (cnt_q != CW'(LOS_N)) cnt_d = cnt_q + 1'b1;
        los_d = (cnt_d == CW'(LOS_N));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      los_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      los_q <= los_d;
    end
  end

  assign los = los_q;
endmodule

// File: rtl/ccd_frame_aligner.sv
module ccd_frame_aligner
  import ccd_pkg::*;
#(
  parameter int BPF    = 8,
  parameter int FPS    = 20,
  parameter int ACQ_N  = 4,
  parameter int MISS_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic super_en,
  input  sym_t sym,
  output logic frame_lock,
  output logic sframe_lock,
  output logic frame_sync,
  output logic sframe_sync
);
  localparam int PW = $clog2(BPF);
  localparam int FW = $clog2(FPS);
  localparam int GW = $clog2(ACQ_N + 1);
  localparam int MW = $clog2(MISS_N + 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [FW-1:0] fidx_q, fidx_d;
  logic [GW-1:0] good_q, good_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          anch_q, anch_d;
  logic          lock_q, lock_d;
  logic          armed_q, armed_d;
  logic          slock_q, slock_d;
  logic          fs_q, fs_d;
  logic          ss_q, ss_d;

  logic          due;
  logic          fidx_last;
  logic          sched_gap;
  logic [PW-1:0] phase_inc;
  logic [FW-1:0] fidx_inc;

  assign due       = (phase_q == PW'(BPF - 1));
  assign phase_inc = due ? '0 : phase_q + 1'b1;
  assign fidx_last = (fidx_q == FW'(FPS - 1));
  assign fidx_inc  = fidx_last ? '0 : fidx_q + 1'b1;
  assign sched_gap = super_en && armed_q && fidx_last;

  always_comb begin
    phase_d = phase_q;
    fidx_d  = fidx_q;
    good_d  = good_q;
    miss_d  = miss_q;
    anch_d  = anch_q;
    lock_d  = lock_q;
    armed_d = armed_q;
    slock_d = slock_q;
    fs_d    = 1'b0;
    ss_d    = 1'b0;
    if (!en) begin
      phase_d = '0;
      fidx_d  = '0;
      good_d  = '0;
      miss_d  = '0;
      anch_d  = 1'b0;
      lock_d  = 1'b0;
      armed_d = 1'b0;
      slock_d = 1'b0;
    end else if (sym.tick) begin
      if (!lock_q) begin
        // hunting for a steady violation spacing
        if (sym.viol) begin
          phase_d = '0;
          anch_d  = 1'b1;
          if (due && anch_q) begin
            if (good_q + 1'b1 == GW'(ACQ_N)) begin
              lock_d  = 1'b1;
              fs_d    = 1'b1;
              good_d  = '0;
              miss_d  = '0;
              fidx_d  = '0;
              armed_d = 1'b0;
              slock_d = 1'b0;
            end else begin
              good_d = good_q + 1'b1;
            end
          end else begin
            good_d = '0;
          end
        end else begin
          phase_d = phase_inc;
          if (due) begin
            good_d = '0;
            anch_d = 1'b0;
          end
        end
      end else begin
        // locked: phase runs free, off-position violations ignored
        phase_d = phase_inc;
        if (due) begin
          fs_d = 1'b1;
          if (sym.viol) begin
            miss_d = '0;
            fidx_d = fidx_inc;
            if (super_en && fidx_last) begin
              armed_d = 1'b0;
              slock_d = 1'b0;
            end
          end else if (sched_gap) begin
            slock_d = 1'b1;
            ss_d    = 1'b1;
            fidx_d  = '0;
          end else begin
            if (super_en && !slock_q) begin
              armed_d = 1'b1;
              fidx_d  = '0;
            end else begin
              fidx_d = fidx_inc;
            end
            if (miss_q + 1'b1 == MW'(MISS_N)) begin
              lock_d  = 1'b0;
              fs_d    = 1'b0;
              miss_d  = '0;
              good_d  = '0;
              anch_d  = 1'b0;
              armed_d = 1'b0;
              slock_d = 1'b0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      fidx_q  <= '0;
      good_q  <= '0;
      miss_q  <= '0;
      anch_q  <= 1'b0;
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
      slock_q <= 1'b0;
      fs_q    <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fidx_q  <= fidx_d;
      good_q  <= good_d;
      miss_q  <= miss_d;
      anch_q  <= anch_d;
      lock_q  <= lock_d;
      armed_q <= armed_d;
      slock_q <= slock_d;
      fs_q    <= fs_d;
      ss_q    <= ss_d;
    end
  end

  assign frame_lock  = lock_q;
  assign sframe_lock = slock_q;
  assign frame_sync  = fs_q;
  assign sframe_sync = ss_q;
endmodule

// File: rtl/cc_violation_decoder.sv
module cc_violation_decoder
  import ccd_pkg::*;
#(
  parameter int BITS_PER_FRAME  = 8,
  parameter int FRAMES_PER_SUPER = 20,
  parameter int ACQUIRE_FRAMES  = 4,
  parameter int MISS_FRAMES     = 3,
  parameter int LOS_BITS        = 32,
  parameter int RST_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       bit_tick_i,
  input  logic       rail_pos_i,
  input  logic       rail_neg_i,
  output logic       bit_stb_o,
  output logic       data_pos_o,
  output logic       data_neg_o,
  output logic       frame_sync_o,
  output logic       sframe_sync_o,
  output logic       frame_lock_o,
  output logic       sframe_lock_o,
  output logic       los_o
);
  logic rst_n_s;
  logic en;
  logic super_en;
  sym_t sym;

  logic stb_q, stb_d;
  logic dp_q, dp_d;
  logic dn_q, dn_d;

  assign en       = mode_valid(mode_i);
  assign super_en = (mode_i == MODE_SUPER);

  ccd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ccd_ami_tracker u_ami (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (en),
    .tick  (bit_tick_i),
    .pos   (rail_pos_i),
    .neg   (rail_neg_i),
    .sym   (sym)
  );

  ccd_frame_aligner #(
    .BPF    (BITS_PER_FRAME),
    .FPS    (FRAMES_PER_SUPER),
    .ACQ_N  (ACQUIRE_FRAMES),
    .MISS_N (MISS_FRAMES)
  ) u_align (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .en          (en),
    .super_en    (super_en),
    .sym         (sym),
    .frame_lock  (frame_lock_o),
    .sframe_lock (sframe_lock_o),
    .frame_sync  (frame_sync_o),
    .sframe_sync (sframe_sync_o)
  );

  ccd_los_monitor #(.LOS_N(LOS_BITS)) u_los (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (en),
    .sym   (sym),
    .los   (los_o)
  );

  always_comb begin
    stb_d = sym.tick;
    dp_d  = sym.mark && sym.pol;
    dn_d  = sym.mark && !sym.pol;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      stb_q <= 1'b0;
      dp_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      dp_q  <= dp_d;
      dn_q  <= dn_d;
    end
  end

  assign bit_stb_o  = stb_q;
  assign data_pos_o = dp_q;
  assign data_neg_o = dn_q;
endmodule

// File: rtl/cc_violation_decoder_chk.sv
module cc_violation_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       bit_tick_i,
  input logic       bit_stb_o,
  input logic       data_pos_o,
  input logic       data_neg_o,
  input logic       frame_sync_o,
  input logic       sframe_sync_o,
  input logic       frame_lock_o,
  input logic       sframe_lock_o,
  input logic       los_o
);
  assert_idle_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_i == 3'b000 || mode_i == 3'b001) |=>
      !(bit_stb_o || data_pos_o || data_neg_o || frame_sync_o ||
        sframe_sync_o || frame_lock_o || sframe_lock_o || los_o));

  assert_strobe_follows_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |-> $past(bit_tick_i));

  assert_rz_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_pos_o || data_neg_o) |-> (bit_stb_o && !(data_pos_o && data_neg_o)));

  assert_lock_rise_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_lock_o) |-> frame_sync_o);

  assert_fsync_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync_o |-> (frame_lock_o && bit_stb_o));

  assert_ssync_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sframe_sync_o |-> (sframe_lock_o && frame_sync_o));

  assert_slock_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sframe_lock_o |-> frame_lock_o);

  assert_los_rise_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_o) |-> (bit_stb_o && !data_pos_o && !data_neg_o));
endmodule

bind cc_violation_decoder cc_violation_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .bit_tick_i    (bit_tick_i),
  .bit_stb_o     (bit_stb_o),
  .data_pos_o    (data_pos_o),
  .data_neg_o    (data_neg_o),
  .frame_sync_o  (frame_sync_o),
  .sframe_sync_o (sframe_sync_o),
  .frame_lock_o  (frame_lock_o),
  .sframe_lock_o (sframe_lock_o),
  .los_o         (los_o)
);

// File: tb/cc_violation_decoder_tb_top.sv
module cc_violation_decoder_tb_top;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode;
  logic       tick;
  logic       rp;
  logic       rn;
  logic       bit_stb, dpos, dneg, fsync, ssync, flock, slock, los;

  int n_chk;
  int n_fail;
  logic enc_pol;

  typedef struct packed {
    logic [2:0] mode;
    int         lead;
    int         nbits;
    int         lock_at;
    int         sf_at;
  } scn_t;

  // mode, leading empty bits, coded bits, lock bit, superframe lock bit (-1 none)
  localparam scn_t SCN [3] = '{
    '{3'b000, 0, 200, 39, -1},
    '{3'b000, 5, 120, 39, -1},
    '{3'b001, 0, 500, 39, 319}
  };

  cc_violation_decoder dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .bit_tick_i    (tick),
    .rail_pos_i    (rp),
    .rail_neg_i    (rn),
    .bit_stb_o     (bit_stb),
    .data_pos_o    (dpos),
    .data_neg_o    (dneg),
    .frame_sync_o  (fsync),
    .sframe_sync_o (ssync),
    .frame_lock_o  (flock),
    .sframe_lock_o (slock),
    .los_o         (los)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode  = m;
    tick  = 1'b0;
    rp    = 1'b0;
    rn    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // drive one bit; on return the outputs it caused are visible
  task automatic send_bit(input logic p, input logic n);
    repeat (2) @(negedge clk);
    tick = 1'b1;
    rp   = p;
    rn   = n;
    @(negedge clk);
    tick = 1'b0;
    rp   = 1'b0;
    rn   = 1'b0;
  endtask

  // composite encoder: every bit a mark, violation on bit 7 of each frame,
  // omitted on frame 19 of every 20 in the extended mode
  task automatic enc_bit(input int k, input logic sup, output logic pol);
    logic v;
    v = (k % 8 == 7) && !(sup && ((k / 8) % 20 == 19));
    if (k == 0) pol = 1'b1;
    else        pol = v ? enc_pol : ~enc_pol;
    enc_pol = pol;
    send_bit(pol, ~pol);
  endtask

  function automatic logic all_quiet();
    return !(bit_stb || dpos || dneg || fsync || ssync || flock || slock || los);
  endfunction

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    mode   = 3'b000;
    tick   = 1'b0;
    rp     = 1'b0;
    rn     = 1'b0;
    enc_pol = 1'b0;

    // R11: reset state
    do_reset(3'b000);
    chk("R11 outputs after reset", all_quiet(), 1'b1);

    // table-driven scenarios
    for (int s = 0; s < 3; s++) begin
      do_reset(SCN[s].mode);
      for (int z = 0; z < SCN[s].lead; z++) begin
        send_bit(1'b0, 1'b0);
        chk("R5 no lock during empty lead", flock, 1'b0);
      end
      for (int k = 0; k < SCN[s].nbits; k++) begin
        logic pol;
        logic le, fe, se, sse, gap;
        enc_bit(k, SCN[s].mode == 3'b001, pol);
        le  = (k >= SCN[s].lock_at);
        fe  = le && (k % 8 == 7);
        se  = (SCN[s].sf_at >= 0) && (k >= SCN[s].sf_at);
        sse = se && ((k - SCN[s].sf_at) % 160 == 0);
        gap = (SCN[s].mode == 3'b001) && (k % 160 == 159);
        chk("R2 bit strobe", bit_stb, 1'b1);
        chk("R3 positive rail data", dpos, pol);
        chk("R3 negative rail data", dneg, ~pol);
        if (gap) chk("R8 lock held over scheduled gap", flock, le);
        else     chk("R4,R5 frame lock", flock, le);
        chk("R6 frame sync", fsync, fe);
        chk("R9 superframe lock", slock, se);
        chk("R9 superframe sync", ssync, sse);
      end
    end

    // R1: reserved and non-composite mode codes keep everything idle
    do_reset(3'b111);
    for (int k = 0; k < 48; k++) begin
      logic pol;
      enc_bit(k, 1'b0, pol);
      chk("R1 mode 111 idle", all_quiet(), 1'b1);
    end
    do_reset(3'b000);
    for (int k = 0; k < 48; k++) begin
      logic pol;
      enc_bit(k, 1'b0, pol);
    end
    chk("R5 locked before mode change", flock, 1'b1);
    mode = 3'b010;
    send_bit(1'b1, 1'b0);
    chk("R1 mode 010 clears outputs", all_quiet(), 1'b1);
    mode = 3'b000;
    send_bit(1'b1, 1'b0);
    chk("R1 lock not retained after idle mode", flock, 1'b0);

    // R3: both rails high is not a mark
    do_reset(3'b000);
    send_bit(1'b1, 1'b1);
    chk("R3 both rails strobe", bit_stb, 1'b1);
    chk("R3 both rails no pos data", dpos, 1'b0);
    chk("R3 both rails no neg data", dneg, 1'b0);

    // R7: lock loss after three missing violations
    do_reset(3'b000);
    for (int k = 0; k < 48; k++) begin
      logic pol;
      enc_bit(k, 1'b0, pol);
    end
    for (int k = 48; k < 72; k++) begin
      enc_pol = ~enc_pol;
      send_bit(enc_pol, ~enc_pol);
      if (k == 55 || k == 63) begin
        chk("R7 lock held after one or two misses", flock, 1'b1);
        chk("R6 flywheel sync on missing violation", fsync, 1'b1);
      end
      if (k == 71) begin
        chk("R7 lock dropped on third miss", flock, 1'b0);
        chk("R7 no sync on dropping tick", fsync, 1'b0);
      end
    end

    // R10: loss-of-signal alarm on an all-zero line
    do_reset(3'b000);
    for (int k = 1; k <= 35; k++) begin
      send_bit(1'b0, 1'b0);
      chk("R10 alarm vs empty bit count", los, (k >= 32));
    end
    send_bit(1'b0, 1'b1);
    chk("R10 alarm cleared by first mark", los, 1'b0);
    chk("R3 negative mark after silence", dneg, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual run still active expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule